// File: doc/BRIEF.md
# Accumulator ALU with BCD-aware flags

This block is the 8-bit arithmetic and logic unit of an accumulator-style microcontroller core. It holds the working register W and the three status bits Carry, Digit Carry and Zero. On each cycle in which an operation is presented, it combines W with a second operand, writes the result and updates the status bits under per-operation rules. The second operand is either the value on the file-register read port or an immediate constant. Single-operand operations use either W or that second operand.

The supported operations are add, subtract, AND, OR, XOR, complement, increment, decrement, rotate left and right through Carry, nibble swap and pass-through. Digit Carry reports the carry out of the low nibble, which lets software adjust packed BCD values. In subtraction, Carry and Digit Carry are reported as inverted borrows. A single destination bit sends the result either to W or to a file-register write strobe. W and the status bits load on the same clock edge at which the file write takes place. Instruction decode, the program counter and the memory arrays are outside the block.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, and after it is released, W reads 0x00, C, DC and Z read 0, and file_wr_en is 0.
- R2: The second operand B is imm when src_imm=1 and file_rd when src_imm=0. The single-operand codes (5,6,7,8,9,10,11) work on W when unary_w=1 and on B when unary_w=0.
- R3: Code 0 (add) produces (B + W) mod 256. C is set on a carry out of bit 7 and DC on a carry from bit 3 into bit 4. Z is set when the 8-bit result is zero.
- R4: Code 1 (subtract) produces (B - W) mod 256. C=1 when B >= W (no borrow). DC=1 when B[3:0] >= W[3:0]. Z is set when the result is zero.
- R5: Codes 2 (B AND W), 3 (B OR W), 4 (B XOR W) and 11 (pass operand) update only Z. C and DC keep their values.
- R6: Codes 5 (bitwise complement), 6 (operand + 1) and 7 (operand - 1) update only Z. Both wrap modulo 256.
- R7: Code 8 produces {op[6:0], C} and loads C from op[7]. Code 9 produces {C, op[7:1]} and loads C from op[0]. DC and Z keep their values.
- R8: Code 10 produces {op[3:0], op[7:4]} and leaves C, DC and Z unchanged.
- R9: With dst_file=1, file_wr_en is high in the operation's cycle, file_wr_data carries the result, and W is unchanged. With dst_file=0, W loads the result at the clock edge and file_wr_en stays low. The status bits load at that same edge in both cases.
- R10: When op_valid=0, or when the code is 12 to 15, W, C, DC and Z are unchanged and file_wr_en stays low.

Codes are the values of the 4-bit `op` input, written in decimal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code |
| src_imm | input | 1 | 1: second operand is imm; 0: second operand is file_rd |
| unary_w | input | 1 | 1: single-operand codes use W |
| dst_file | input | 1 | 1: result goes to the file write port; 0: result goes to W |
| file_rd | input | 8 | File-register read data |
| imm | input | 8 | Immediate constant |
| file_wr_en | output | 1 | File-register write strobe |
| file_wr_data | output | 8 | File-register write data |
| w_q | output | 8 | Working register |
| c_q | output | 1 | Carry, or inverted borrow in subtraction |
| dc_q | output | 1 | Digit Carry, or inverted nibble borrow in subtraction |
| z_q | output | 1 | Zero |

## Verification
The assertions take for granted that op, src_imm, unary_w, dst_file, file_rd and imm are driven to known values whenever op_valid is high, and that file_rd holds steady for the whole cycle. The assertions relate only the operation presented in a cycle to the state one edge later. The bench changes every input once per cycle, on the falling edge, so it never breaks these assumptions. It mixes directed carry, borrow and wrap cases with a long run of random codes, including the unused codes 12 to 15 and idle cycles.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_COM  = 4'd5,
      OP_INC  = 4'd6,
      OP_DEC  = 4'd7,
      OP_RL   = 4'd8,
      OP_RR   = 4'd9,
      OP_SWAP = 4'd10,
      OP_PASS = 4'd11
   } alu_op_e;

   typedef struct packed {
      logic legal;
      logic upd_c;
      logic upd_dc;
      logic upd_z;
   } flag_ctl_t;

endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] w,
   input  logic [DW-1:0] file_rd,
   input  logic [DW-1:0] imm,
   input  logic          src_imm,
   input  logic          unary_w,
   output logic [DW-1:0] b_opnd,
   output logic [DW-1:0] u_opnd
);

   assign b_opnd = src_imm ? imm : file_rd;
   assign u_opnd = unary_w ? w : b_opnd;

endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int DW          = 8,
   parameter int NIB_W       = 4,
   parameter bit SPLIT_CHAIN = 1'b1
) (
   input  logic [DW-1:0] x,
   input  logic [DW-1:0] y,
   input  logic          ci,
   output logic [DW-1:0] sum,
   output logic          co,
   output logic          dco
);

   localparam int HI_W = DW - NIB_W;

   generate
      if (SPLIT_CHAIN) begin : g_split
         logic [NIB_W:0] lo;
         logic [HI_W:0]  hi;
         always_comb begin
            lo = {1'b0, x[NIB_W-1:0]} + {1'b0, y[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
            hi = {1'b0, x[DW-1:NIB_W]} + {1'b0, y[DW-1:NIB_W]} + {{HI_W{1'b0}}, lo[NIB_W]};
         end
         assign sum = {hi[HI_W-1:0], lo[NIB_W-1:0]};
         assign co  = hi[HI_W];
         assign dco = lo[NIB_W];
      end else begin : g_flat
         logic [DW:0] full;
         assign full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
         assign sum  = full[DW-1:0];
         assign co   = full[DW];
         assign dco  = x[NIB_W] ^ y[NIB_W] ^ full[NIB_W];
      end
   endgenerate

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int DW          = 8,
   parameter int NIB_W       = 4,
   parameter bit SPLIT_CHAIN = 1'b1
) (
   input  logic [OP_W-1:0] op,
   input  logic [DW-1:0]   w,
   input  logic [DW-1:0]   b,
   input  logic [DW-1:0]   u,
   input  logic            c_in,
   output logic [DW-1:0]   res,
   output logic            c_new,
   output logic            dc_new
);

   localparam int            HALF = DW / 2;
   localparam logic [DW-1:0] ONE  = DW'(1);

   alu_op_e       opc;
   logic [DW-1:0] add_y;
   logic          add_ci;
   logic [DW-1:0] add_sum;
   logic          add_co;
   logic          add_dco;

   assign opc    = alu_op_e'(op);
   assign add_ci = (opc == OP_SUB);
   assign add_y  = add_ci ? ~w : w;

   acc_alu_adder #(
      .DW          (DW),
      .NIB_W       (NIB_W),
      .SPLIT_CHAIN (SPLIT_CHAIN)
   ) i_adder (
      .x   (b),
      .y   (add_y),
      .ci  (add_ci),
      .sum (add_sum),
      .co  (add_co),
      .dco (add_dco)
   );

   always_comb begin
      res    = '0;
      c_new  = c_in;
      dc_new = 1'b0;
      case (opc)
         OP_ADD, OP_SUB: begin
            res    = add_sum;
            c_new  = add_co;
            dc_new = add_dco;
         end
         OP_AND:  res = b & w;
         OP_OR:   res = b | w;
         OP_XOR:  res = b ^ w;
         OP_COM:  res = ~u;
         OP_INC:  res = u + ONE;
         OP_DEC:  res = u - ONE;
         OP_RL: begin
            res   = {u[DW-2:0], c_in};
            c_new = u[DW-1];
         end
         OP_RR: begin
            res   = {c_in, u[DW-1:1]};
            c_new = u[0];
         end
         OP_SWAP: res = {u[HALF-1:0], u[DW-1:HALF]};
         OP_PASS: res = u;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/acc_alu_flagctl.sv
module acc_alu_flagctl
   import acc_alu_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output flag_ctl_t       ctl
);

   always_comb begin
      ctl = '0;
      case (alu_op_e'(op))
         OP_ADD, OP_SUB:
            ctl = '{legal: 1'b1, upd_c: 1'b1, upd_dc: 1'b1, upd_z: 1'b1};
         OP_AND, OP_OR, OP_XOR, OP_COM, OP_INC, OP_DEC, OP_PASS:
            ctl = '{legal: 1'b1, upd_c: 1'b0, upd_dc: 1'b0, upd_z: 1'b1};
         OP_RL, OP_RR:
            ctl = '{legal: 1'b1, upd_c: 1'b1, upd_dc: 1'b0, upd_z: 1'b0};
         OP_SWAP:
            ctl = '{legal: 1'b1, upd_c: 1'b0, upd_dc: 1'b0, upd_z: 1'b0};
         default:
            ctl = '0;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DW          = 8,
   parameter int NIB_W       = 4,
   parameter bit SPLIT_CHAIN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [OP_W-1:0] op,
   input  logic            src_imm,
   input  logic            unary_w,
   input  logic            dst_file,
   input  logic [DW-1:0]   file_rd,
   input  logic [DW-1:0]   imm,
   output logic            file_wr_en,
   output logic [DW-1:0]   file_wr_data,
   output logic [DW-1:0]   w_q,
   output logic            c_q,
   output logic            dc_q,
   output logic            z_q
);

   generate
      if ((DW % 2) != 0 || DW < 2 * NIB_W) begin : g_bad_width
         $error("acc_alu: DW must be even and at least twice NIB_W");
      end
      if (NIB_W < 1) begin : g_bad_nib
         $error("acc_alu: NIB_W must be positive");
      end
   endgenerate

   logic [DW-1:0] b_opnd;
   logic [DW-1:0] u_opnd;
   logic [DW-1:0] res;
   logic          c_new;
   logic          dc_new;
   flag_ctl_t     fctl;
   logic          fire;

   acc_alu_opsel #(.DW(DW)) i_opsel (
      .w       (w_q),
      .file_rd (file_rd),
      .imm     (imm),
      .src_imm (src_imm),
      .unary_w (unary_w),
      .b_opnd  (b_opnd),
      .u_opnd  (u_opnd)
   );

   acc_alu_core #(
      .DW          (DW),
      .NIB_W       (NIB_W),
      .SPLIT_CHAIN (SPLIT_CHAIN)
   ) i_core (
      .op     (op),
      .w      (w_q),
      .b      (b_opnd),
      .u      (u_opnd),
      .c_in   (c_q),
      .res    (res),
      .c_new  (c_new),
      .dc_new (dc_new)
   );

   acc_alu_flagctl i_flagctl (
      .op  (op),
      .ctl (fctl)
   );

   assign fire         = op_valid & fctl.legal;
   assign file_wr_en   = fire & dst_file;
   assign file_wr_data = res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q  <= '0;
         c_q  <= 1'b0;
         dc_q <= 1'b0;
         z_q  <= 1'b0;
      end else if (fire) begin
         if (!dst_file)   w_q  <= res;
         if (fctl.upd_c)  c_q  <= c_new;
         if (fctl.upd_dc) dc_q <= dc_new;
         if (fctl.upd_z)  z_q  <= (res == '0);
      end
   end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          op_valid,
   input logic [3:0]    op,
   input logic          src_imm,
   input logic          unary_w,
   input logic          dst_file,
   input logic [DW-1:0] file_rd,
   input logic [DW-1:0] imm,
   input logic          file_wr_en,
   input logic [DW-1:0] file_wr_data,
   input logic [DW-1:0] w_q,
   input logic          c_q,
   input logic          dc_q,
   input logic          z_q
);

   logic [DW-1:0] sel_b;
   logic          act;
   logic          zop;

   assign sel_b = src_imm ? imm : file_rd;
   assign act   = op_valid && (op <= 4'd11);
   assign zop   = op_valid && ((op <= 4'd7) || (op == 4'd11));

   // R9
   file_dst_w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && dst_file) |=> $stable(w_q));

   // R9
   w_dst_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !dst_file) |-> !file_wr_en);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> ($stable(w_q) && $stable(c_q) && $stable(dc_q) && $stable(z_q)));

   // R10
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> !file_wr_en);

   // R8
   swap_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == 4'd10) |=> ($stable(c_q) && $stable(dc_q) && $stable(z_q)));

   // R5
   logic_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op >= 4'd2 && op <= 4'd4) |=> ($stable(c_q) && $stable(dc_q)));

   // R6
   unary_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op >= 4'd5 && op <= 4'd7) |=> ($stable(c_q) && $stable(dc_q)));

   // R7
   rot_dc_z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op == 4'd8 || op == 4'd9)) |=> ($stable(dc_q) && $stable(z_q)));

   // R3
   w_zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zop && !dst_file) |=> (z_q == (w_q == '0)));

   // R4
   sub_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == 4'd1 && sel_b == w_q) |=> (c_q && dc_q && z_q));

   // R6
   inc_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == 4'd6 && dst_file && !unary_w) |-> (file_wr_data == sel_b + DW'(1)));

endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) i_acc_alu_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid     (op_valid),
   .op           (op),
   .src_imm      (src_imm),
   .unary_w      (unary_w),
   .dst_file     (dst_file),
   .file_rd      (file_rd),
   .imm          (imm),
   .file_wr_en   (file_wr_en),
   .file_wr_data (file_wr_data),
   .w_q          (w_q),
   .c_q          (c_q),
   .dc_q         (dc_q),
   .z_q          (z_q)
);

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op = '0;
   logic       src_imm = 1'b0;
   logic       unary_w = 1'b0;
   logic       dst_file = 1'b0;
   logic [7:0] file_rd = '0;
   logic [7:0] imm = '0;
   logic       file_wr_en;
   logic [7:0] file_wr_data;
   logic [7:0] w_q;
   logic       c_q, dc_q, z_q;

   always #2 clk = ~clk;

   acc_alu i_acc_alu (
      .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op (op),
      .src_imm (src_imm), .unary_w (unary_w), .dst_file (dst_file),
      .file_rd (file_rd), .imm (imm), .file_wr_en (file_wr_en),
      .file_wr_data (file_wr_data), .w_q (w_q), .c_q (c_q),
      .dc_q (dc_q), .z_q (z_q)
   );

   typedef struct {
      bit         fw_en;
      logic [7:0] fw_d;
      logic [7:0] w;
      bit         c, dc, z;
      string      req;
   } exp_t;

   exp_t       sb[$];
   int         n_cmp = 0;
   int         n_bad = 0;
   logic [7:0] m_w = '0;
   bit         m_c = 0, m_dc = 0, m_z = 0;

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input bit v, input logic [3:0] o, input bit si,
                        input bit uw, input bit df, input logic [7:0] f,
                        input logic [7:0] im, input string req);
      exp_t       e;
      logic [7:0] b, u, r;
      bit         nc, ndc, uc, udc, uz, lg;
      @(negedge clk);
      op_valid = v; op = o; src_imm = si; unary_w = uw;
      dst_file = df; file_rd = f; imm = im;
      b   = si ? im : f;
      u   = uw ? m_w : b;
      r   = '0; nc = m_c; ndc = 0;
      lg  = v && (o <= 4'd11);
      uc  = 0; udc = 0; uz = 0;
      case (o)
         4'd0: begin r = b + m_w; nc = ({1'b0, b} + {1'b0, m_w}) > 9'd255;
                     ndc = (b[3:0] + m_w[3:0]) > 5'd15; uc = 1; udc = 1; uz = 1; end
         4'd1: begin r = b - m_w; nc = (b >= m_w); ndc = (b[3:0] >= m_w[3:0]);
                     uc = 1; udc = 1; uz = 1; end
         4'd2: begin r = b & m_w; uz = 1; end
         4'd3: begin r = b | m_w; uz = 1; end
         4'd4: begin r = b ^ m_w; uz = 1; end
         4'd5: begin r = ~u; uz = 1; end
         4'd6: begin r = u + 8'd1; uz = 1; end
         4'd7: begin r = u - 8'd1; uz = 1; end
         4'd8: begin r = {u[6:0], m_c}; nc = u[7]; uc = 1; end
         4'd9: begin r = {m_c, u[7:1]}; nc = u[0]; uc = 1; end
         4'd10: r = {u[3:0], u[7:4]};
         4'd11: begin r = u; uz = 1; end
         default: r = '0;
      endcase
      e.fw_en = lg && df;
      e.fw_d  = r;
      if (lg) begin
         if (!df) m_w = r;
         if (uc)  m_c = nc;
         if (udc) m_dc = ndc;
         if (uz)  m_z = (r == 8'h00);
      end
      e.w = m_w; e.c = m_c; e.dc = m_dc; e.z = m_z; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: combinational write port before the edge, registers after it
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            chk(e.req, "file_wr_en", {7'd0, file_wr_en}, {7'd0, e.fw_en});
            if (e.fw_en) chk(e.req, "file_wr_data", file_wr_data, e.fw_d);
            @(posedge clk);
            #1;
            chk(e.req, "w_q", w_q, e.w);
            chk(e.req, "c_q", {7'd0, c_q}, {7'd0, e.c});
            chk(e.req, "dc_q", {7'd0, dc_q}, {7'd0, e.dc});
            chk(e.req, "z_q", {7'd0, z_q}, {7'd0, e.z});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 during reset
      chk("R1", "w_q in reset", w_q, 8'h00);
      chk("R1", "flags in reset", {5'd0, c_q, dc_q, z_q}, 8'h00);
      chk("R1", "file_wr_en in reset", {7'd0, file_wr_en}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      drive(0, 4'd0, 0, 0, 0, 8'h00, 8'h00, "R1 idle after reset");
      // loads and add carry cases
      drive(1, 4'd11, 1, 0, 0, 8'hFF, 8'h3A, "R2 pass imm to W");
      drive(1, 4'd0, 0, 0, 0, 8'h0C, 8'h77, "R3 add digit carry");
      drive(1, 4'd0, 1, 0, 0, 8'h11, 8'hBA, "R3 add wrap to zero");
      drive(1, 4'd11, 1, 0, 0, 8'h00, 8'h10, "R2 pass imm");
      drive(1, 4'd1, 0, 0, 0, 8'h10, 8'h00, "R4 sub equal");
      drive(1, 4'd11, 1, 0, 0, 8'h00, 8'h01, "R2 pass imm");
      drive(1, 4'd1, 0, 0, 1, 8'h00, 8'h55, "R4 sub borrow to file");
      drive(1, 4'd1, 1, 0, 0, 8'hAA, 8'h20, "R4 sub nibble borrow");
      drive(1, 4'd8, 0, 0, 1, 8'h80, 8'h00, "R7 rotate left file");
      drive(1, 4'd9, 0, 1, 0, 8'h00, 8'h00, "R7 rotate right W");
      drive(1, 4'd10, 1, 0, 0, 8'h00, 8'h5A, "R8 swap imm");
      drive(1, 4'd6, 0, 0, 1, 8'hFF, 8'h00, "R6 increment wraps");
      drive(1, 4'd7, 0, 1, 0, 8'h00, 8'h00, "R6 decrement W");
      drive(1, 4'd5, 1, 0, 1, 8'h00, 8'hFF, "R6 complement to zero");
      drive(1, 4'd2, 1, 0, 0, 8'h00, 8'h0F, "R5 and imm");
      drive(1, 4'd3, 0, 0, 1, 8'hF0, 8'h00, "R5 or file");
      drive(1, 4'd4, 0, 0, 0, 8'h00, 8'h00, "R5 xor zero operand");
      drive(1, 4'd11, 0, 1, 1, 8'h00, 8'h00, "R9 store W to file");
      drive(1, 4'd12, 1, 0, 0, 8'h00, 8'h99, "R10 unused code 12");
      drive(1, 4'd15, 0, 0, 1, 8'h42, 8'h00, "R10 unused code 15");
      drive(0, 4'd0, 1, 0, 0, 8'h00, 8'h01, "R10 op_valid low");
      for (int i = 0; i < 600; i++) begin
         drive($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
               8'($urandom_range(0, 255)), "R9 random mix");
      end
      wait (sb.size() == 0);
      repeat (2) @(posedge clk);
      #1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule